// File: doc/BRIEF.md
# Ping-Pong Partitioned Buffer Writer

This block takes a stream of data words from a disk burst engine and stores them in one of two external buffer memories. A select flag picks the buffer being filled. The other buffer is left to a reader, which drains it towards the channel outputs. Each buffer is split into equal partitions, one per video channel. Incoming words are spread across the partitions in interleaved order: the partition index moves on with every word, and the offset inside a partition moves on only after every partition has taken one word. The write address is therefore the partition base plus the offset.

One burst fills exactly one buffer. When the buffer being filled is full, the block drops its ready signal and holds off the source. It waits until the reader reports that the other buffer has been fully drained. The two buffers then change roles. The flag toggles, a one-cycle swap pulse is raised, and filling starts again at partition 0, offset 0. After reset both buffers count as empty, so the first completed fill hands over at once without any drain report.

Top module: `pingpong_part_writer`

## Requirements
- R1: After reset, `buf_sel` is 0, `in_ready` is 1, `swap_pulse` is 0 and neither write enable is active.
- R2: While `buf_sel` is 0, writes go only to the buffer 0 port. While it is 1, writes go only to the buffer 1 port. The two enables are never active together.
- R3: The write address is `{partition, offset}`, so it equals partition*PART_DEPTH + offset. The partition index is the upper bits and the offset is the lower bits, and PART_DEPTH is a power of two. Word n of a fill goes to partition n mod NUM_PART at offset n div NUM_PART.
- R4: A write enable is active exactly in a cycle where `in_valid` and `in_ready` are both high. The written data equals `in_data` of that cycle.
- R5: After NUM_PART*PART_DEPTH words have been accepted, `in_ready` stays low and no write occurs, whatever `in_valid` does, until the swap.
- R6: If the other buffer is already known to be empty when the fill completes, the swap happens on the next clock edge. This is always the case for the first fill after reset, so no drain report is needed then.
- R7: A `drain_done` pulse while the block is waiting causes the swap on that same clock edge. `swap_pulse` is high for exactly one cycle, and this is the cycle in which `buf_sel` first shows its toggled value. `buf_sel` changes at no other time.
- R8: A `drain_done` pulse that arrives while a fill is in progress is remembered, and it lets the swap happen right after the fill completes.
- R9: After a swap, the first accepted word goes to address 0 (partition 0, offset 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | DATA_W | Word from the burst engine |
| in_valid | input | 1 | in_data holds a word |
| in_ready | output | 1 | Block can accept a word this cycle |
| drain_done | input | 1 | Reader finished draining the other buffer (pulse) |
| buf0_we | output | 1 | Write enable, buffer 0 |
| buf0_addr | output | ADDR_W | Write address, buffer 0 |
| buf0_data | output | DATA_W | Write data, buffer 0 |
| buf1_we | output | 1 | Write enable, buffer 1 |
| buf1_addr | output | ADDR_W | Write address, buffer 1 |
| buf1_data | output | DATA_W | Write data, buffer 1 |
| buf_sel | output | 1 | Buffer being filled (0 or 1) |
| swap_pulse | output | 1 | One-cycle pulse when the roles change |

## Verification
The bound checker watches several rules on every cycle:
- the two write enables are mutually exclusive;
- no write happens while ready is low;
- the hold lasts until a swap;
- the flag changes only together with the swap pulse;
- the address steps one partition base per word inside a round;
- every swap starts again at address 0.

Only the bench scenarios can show that the whole interleaved address sequence of a complete fill is right. They also show that the first hand-over needs no drain report, that an early drain report is remembered, and that a late one releases the hold on its own edge.

// File: rtl/pp_wr_pkg.sv
package pp_wr_pkg;
  typedef enum logic {
    ST_FILL = 1'b0,
    ST_HOLD = 1'b1
  } wr_state_e;
endpackage

// File: rtl/pp_addr_gen.sv
// Interleaved address counter: partition index is the fast digit,
// in-partition offset the slow digit.
module pp_addr_gen #(
  parameter int NUM_PART   = 32,
  parameter int PART_DEPTH = 32,
  localparam int PART_W = $clog2(NUM_PART),
  localparam int OFF_W  = $clog2(PART_DEPTH),
  localparam int ADDR_W = PART_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              clr,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);
  localparam logic [PART_W-1:0] PART_MAX = PART_W'(NUM_PART - 1);
  localparam logic [OFF_W-1:0]  OFF_MAX  = OFF_W'(PART_DEPTH - 1);

  logic [PART_W-1:0] part_q, part_d;
  logic [OFF_W-1:0]  off_q,  off_d;
  logic              part_wrap;

  assign part_wrap = (part_q == PART_MAX);
  assign last      = part_wrap && (off_q == OFF_MAX);
  assign addr      = {part_q, off_q};

  always_comb begin
    part_d = part_q;
    off_d  = off_q;
    if (clr) begin
      part_d = '0;
      off_d  = '0;
    end else if (adv) begin
      if (part_wrap) begin
        part_d = '0;
        off_d  = (off_q == OFF_MAX) ? '0 : off_q + 1'b1;
      end else begin
        part_d = part_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      part_q <= '0;
      off_q  <= '0;
    end else if (adv || clr) begin
      part_q <= part_d;
      off_q  <= off_d;
    end
  end
endmodule

// File: rtl/pp_swap_ctrl.sv
// Fill/hold sequencing, buffer flag and drain bookkeeping.
module pp_swap_ctrl
  import pp_wr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic last_accept,
  input  logic drain_done,
  output logic hold,
  output logic swap_now,
  output logic sel,
  output logic swap_pulse
);
  wr_state_e state_q, state_d;
  logic      sel_d;
  logic      other_empty_q, other_empty_d;
  logic      pulse_d;

  assign hold     = (state_q == ST_HOLD);
  assign swap_now = hold && (other_empty_q || drain_done);

  always_comb begin
    state_d       = state_q;
    sel_d         = sel;
    other_empty_d = other_empty_q;
    pulse_d       = 1'b0;
    if (drain_done)
      other_empty_d = 1'b1;
    unique case (state_q)
      ST_FILL: if (last_accept) state_d = ST_HOLD;
      ST_HOLD: if (swap_now) begin
        state_d       = ST_FILL;
        sel_d         = ~sel;
        other_empty_d = 1'b0;
        pulse_d       = 1'b1;
      end
      default: state_d = ST_FILL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= ST_FILL;
      sel           <= 1'b0;
      other_empty_q <= 1'b1;
      swap_pulse    <= 1'b0;
    end else begin
      state_q       <= state_d;
      sel           <= sel_d;
      other_empty_q <= other_empty_d;
      swap_pulse    <= pulse_d;
    end
  end
endmodule

// File: rtl/pp_port_mux.sv
// Steers the accepted word to the selected buffer port.
module pp_port_mux #(
  parameter int NUM_PORTS = 2,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 10,
  localparam int SEL_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                  fire,
  input  logic [SEL_W-1:0]      sel,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     data,
  output logic [NUM_PORTS-1:0]  we,
  output logic [ADDR_W-1:0]     port_addr [NUM_PORTS],
  output logic [DATA_W-1:0]     port_data [NUM_PORTS]
);
  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    assign we[i]        = fire && (sel == SEL_W'(i));
    assign port_addr[i] = addr;
    assign port_data[i] = data;
  end
endmodule

// File: rtl/pingpong_part_writer.sv
module pingpong_part_writer #(
  parameter int DATA_W     = 16,
  parameter int NUM_PART   = 32,
  parameter int PART_DEPTH = 32,
  localparam int ADDR_W = $clog2(NUM_PART) + $clog2(PART_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              drain_done,
  output logic              buf0_we,
  output logic [ADDR_W-1:0] buf0_addr,
  output logic [DATA_W-1:0] buf0_data,
  output logic              buf1_we,
  output logic [ADDR_W-1:0] buf1_addr,
  output logic [DATA_W-1:0] buf1_data,
  output logic              buf_sel,
  output logic              swap_pulse
);
  logic              hold, swap_now, fire, last;
  logic [ADDR_W-1:0] addr;
  logic [1:0]        we;
  logic [ADDR_W-1:0] p_addr [2];
  logic [DATA_W-1:0] p_data [2];

  assign in_ready = !hold;
  assign fire     = in_valid && in_ready;

  pp_addr_gen #(.NUM_PART(NUM_PART), .PART_DEPTH(PART_DEPTH)) u_addr (
    .clk(clk), .rst_n(rst_n), .adv(fire), .clr(swap_now),
    .addr(addr), .last(last)
  );

  pp_swap_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .last_accept(fire && last),
    .drain_done(drain_done), .hold(hold), .swap_now(swap_now),
    .sel(buf_sel), .swap_pulse(swap_pulse)
  );

  pp_port_mux #(.NUM_PORTS(2), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mux (
    .fire(fire), .sel(buf_sel), .addr(addr), .data(in_data),
    .we(we), .port_addr(p_addr), .port_data(p_data)
  );

  assign buf0_we   = we[0];
  assign buf1_we   = we[1];
  assign buf0_addr = p_addr[0];
  assign buf1_addr = p_addr[1];
  assign buf0_data = p_data[0];
  assign buf1_data = p_data[1];
endmodule

// File: rtl/pp_writer_checker.sv
module pp_writer_checker #(
  parameter int DATA_W     = 16,
  parameter int NUM_PART   = 32,
  parameter int PART_DEPTH = 32,
  localparam int OFF_W  = $clog2(PART_DEPTH),
  localparam int ADDR_W = $clog2(NUM_PART) + OFF_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              buf0_we,
  input logic [ADDR_W-1:0] buf0_addr,
  input logic              buf1_we,
  input logic              buf_sel,
  input logic              swap_pulse
);
  localparam int PART_W = ADDR_W - OFF_W;
  logic wr;
  assign wr = buf0_we || buf1_we;

  assert_port_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({buf0_we, buf1_we}));

  assert_port_matches_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (buf0_we |-> !buf_sel) and (buf1_we |-> buf_sel));

  assert_no_write_in_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> !wr);

  assert_hold_until_swap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> (!in_ready || swap_pulse));

  assert_write_needs_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> in_valid);

  assert_flag_only_on_swap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !swap_pulse |-> $stable(buf_sel));

  assert_flag_toggles_on_swap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    swap_pulse |-> (buf_sel != $past(buf_sel)));

  assert_restart_at_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    swap_pulse |-> (buf0_addr == '0));

  assert_partition_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (buf0_addr[ADDR_W-1:OFF_W] != PART_W'(NUM_PART - 1)))
      |=> (buf0_addr == $past(buf0_addr) + ADDR_W'(PART_DEPTH)));
endmodule

bind pingpong_part_writer pp_writer_checker #(
  .DATA_W(DATA_W), .NUM_PART(NUM_PART), .PART_DEPTH(PART_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .buf0_we(buf0_we), .buf0_addr(buf0_addr), .buf1_we(buf1_we),
  .buf_sel(buf_sel), .swap_pulse(swap_pulse)
);

// File: tb/tb_pingpong_part_writer.sv
`timescale 1ns/1ps
module tb_pingpong_part_writer;
  localparam int DW = 16, NP = 32, PD = 32, AW = 10, WORDS = NP * PD;

  logic clk, rst_n, in_valid, in_ready, drain_done;
  logic [DW-1:0] in_data;
  logic buf0_we, buf1_we, buf_sel, swap_pulse;
  logic [AW-1:0] buf0_addr, buf1_addr;
  logic [DW-1:0] buf0_data, buf1_data;

  int checks = 0, fails = 0;

  pingpong_part_writer #(.DATA_W(DW), .NUM_PART(NP), .PART_DEPTH(PD)) dut (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .drain_done(drain_done),
    .buf0_we(buf0_we), .buf0_addr(buf0_addr), .buf0_data(buf0_data),
    .buf1_we(buf1_we), .buf1_addr(buf1_addr), .buf1_data(buf1_data),
    .buf_sel(buf_sel), .swap_pulse(swap_pulse)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Fill the active buffer; gap>0 inserts idle cycles between words.
  // drain_at >= 0 pulses drain_done alongside word index drain_at.
  task automatic fill(input int fidx, input int gap, input int drain_at);
    int n = 0;
    int exp_sel = fidx % 2;
    while (n < WORDS) begin
      @(negedge clk);
      in_valid   = 1'b1;
      in_data    = DW'(fidx * 4096 + n);
      drain_done = (n == drain_at);
      #1;
      chk("R5 ready during fill", in_ready, 1);
      chk("R2 write port", exp_sel ? buf1_we : buf0_we, 1);
      chk("R2 idle port", exp_sel ? buf0_we : buf1_we, 0);
      chk("R3 address", exp_sel ? buf1_addr : buf0_addr, (n % NP) * PD + n / NP);
      chk("R4 data", exp_sel ? buf1_data : buf0_data, fidx * 4096 + n);
      n++;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        in_valid   = 1'b0;
        drain_done = 1'b0;
        #1;
        chk("R4 no write without valid", int'(buf0_we | buf1_we), 0);
      end
    end
    @(negedge clk);
    in_valid   = 1'b1;
    drain_done = 1'b0;
    #1;
    chk("R5 ready low when full", in_ready, 0);
    chk("R5 write ignored when full", int'(buf0_we | buf1_we), 0);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; drain_done = 1'b0; in_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R1 sel", buf_sel, 0);
    chk("R1 ready", in_ready, 1);
    chk("R1 swap", swap_pulse, 0);
    chk("R1 we", int'(buf0_we | buf1_we), 0);

    // First fill: buffer 0, dense stream, no drain report needed (R6)
    fill(0, 0, -1);
    @(negedge clk); #1;
    chk("R6 first swap without drain", swap_pulse, 1);
    chk("R7 sel toggled", buf_sel, 1);
    chk("R9 restart address", buf1_addr, 0);
    chk("R6 ready after swap", in_ready, 1);

    // Second fill: buffer 1, gapped stream, late drain report
    in_valid = 1'b0;
    fill(1, 1, -1);
    for (int w = 0; w < 20; w++) begin
      @(negedge clk); in_valid = 1'b1; #1;
      chk("R5 held without drain", in_ready, 0);
      chk("R5 no write while held", int'(buf0_we | buf1_we), 0);
      chk("R7 no swap while held", swap_pulse, 0);
      chk("R7 sel stable while held", buf_sel, 1);
    end
    @(negedge clk); in_valid = 1'b0; drain_done = 1'b1;
    @(negedge clk); drain_done = 1'b0; #1;
    chk("R7 swap on drain edge", swap_pulse, 1);
    chk("R7 sel toggled", buf_sel, 0);
    @(negedge clk); #1;
    chk("R7 pulse one cycle", swap_pulse, 0);

    // Third fill: buffer 0, early drain report remembered (R8)
    fill(2, 0, 300);
    @(negedge clk); in_valid = 1'b0; #1;
    chk("R8 early drain remembered", swap_pulse, 1);
    chk("R8 sel toggled", buf_sel, 1);

    // Fourth fill: buffer 1; no report since swap -> must hold (R5)
    fill(3, 0, -1);
    repeat (5) begin
      @(negedge clk); #1;
      chk("R8 stale drain not reused", swap_pulse, 0);
      chk("R5 still held", in_ready, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule